// File: doc/BRIEF.md
# GF(2) Hashed Address Lookup Engine

This block resolves a 48-bit network address to a record index. It first hashes the address. The address and a programmable 48-bit multiplier are both treated as polynomials over GF(2). Their product is reduced modulo the fixed degree-48 generator X^48 + X^36 + X^25 + X^10 + 1. This mapping is a bijection on 48-bit values. The low index bits of the hash select a bucket word in an external table. The remaining upper bits form a tag. Because the mapping is a bijection, a matching tag inside a bucket identifies the address exactly.

The bucket word holds a valid flag, a collision count from 1 to 7, a record pointer and the tag of the first record. The other colliding tags are packed two per 64-bit word, starting at a record region offset by the pointer. The engine walks those words in order until a tag matches or the count is exhausted. It uses one synchronous read port with a latency of one cycle and never issues more than four reads per lookup. The result is returned as a one-cycle done pulse, together with a hit flag and the record index.

Top module: `addr_hash_lookup`

## Requirements
- R1: The hash equals M(X)·A(X) mod (X^48+X^36+X^25+X^10+1), computed one multiplier bit per cycle. The first read of a lookup goes to word address hash[15:0].
- R2: Bucket word layout: bit 31 is valid, bits 30:28 are the count, bits 19:0 are the pointer, and bits 63:32 hold tag 0. If valid is 0 or the count is 0, the lookup ends as a miss after the single bucket read.
- R3: If hash[47:16] equals tag 0 and the bucket is valid, the lookup is a hit with rec_idx = pointer. With a count of 1 and no match, it is a miss after one read.
- R4: For a count of 2 to 7, tags 1 to 6 are packed at word REC_BASE+pointer+j. Bits 31:0 of that word hold tag 2j+1 and bits 63:32 hold tag 2j+2. Words are read in increasing j. A tag whose position is at or above the count is ignored. The first matching position p gives rec_idx = pointer+p.
- R5: A lookup issues at most four reads. Reading stops at the first match. Read strobes are never asserted in two consecutive cycles.
- R6: done is high for exactly one cycle per lookup. hit and rec_idx are valid with done. A miss reports rec_idx 0.
- R7: A start pulse that arrives while a lookup is in progress is ignored. It produces no second result.
- R8: After reset, done, hit, rec_idx and mem_rd_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a lookup (taken only when idle) |
| lookup_addr | input | 48 | Address to resolve |
| hash_mult | input | 48 | Programmable nonzero hash multiplier |
| mem_rd_en | output | 1 | Read strobe to table memory |
| mem_addr | output | MEM_AW (21) | Word address of the read |
| mem_rdata | input | WORD_W (64) | Read data, valid one cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Address found |
| rec_idx | output | PTR_W (20) | Matching record index, 0 on miss |

## Verification
The bench builds the engine with its default parameters: 16 index bits, which leave a 32-bit tag, a 20-bit pointer, 64-bit words and a record region at word 65536. These values exercise the full 48-bit reduction path, including carries out of bit 47. Every collision count from 0 to 7 is reachable, and so is every tag position, which covers read counts of one to four. The table sits in a sparse memory model, so the 64K-entry bucket space can be addressed at full size.

// File: rtl/ahl_pkg.sv
package ahl_pkg;
  localparam int HASH_W = 48;
  // generator without its X^48 term: X^36 + X^25 + X^10 + 1
  localparam logic [HASH_W-1:0] GEN_LOW = 48'h0010_0200_0401;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HASH,
    ST_BKT_REQ,
    ST_BKT_DATA,
    ST_REC_REQ,
    ST_REC_DATA
  } lk_state_e;
endpackage

// File: rtl/gf2_serial_mulmod.sv
module gf2_serial_mulmod
  import ahl_pkg::*;
#(
  parameter int W = HASH_W,
  parameter logic [W-1:0] POLY_LOW = GEN_LOW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] product
);
  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     acc_q, a_q, m_q;
  logic [CNT_W-1:0] bit_q;
  logic             busy_q, done_q;
  logic [W-1:0]     shifted, acc_nxt;

  // Horner step, multiplier MSB first: acc = acc*X mod G, then add A when bit set
  always_comb begin
    shifted = {acc_q[W-2:0], 1'b0} ^ (acc_q[W-1] ? POLY_LOW : '0);
    acc_nxt = shifted ^ (m_q[bit_q] ? a_q : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      a_q    <= '0;
      m_q    <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        a_q    <= a;
        m_q    <= m;
        acc_q  <= '0;
        bit_q  <= CNT_W'(W-1);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        acc_q <= acc_nxt;
        if (bit_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          bit_q <= bit_q - 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign product = acc_q;

  // independent cycle counter for the serial window
  logic [CNT_W:0] cyc_q;
  always_ff @(posedge clk) begin
    if (rst)                   cyc_q <= '0;
    else if (!busy_q && start) cyc_q <= '0;
    else if (busy_q)           cyc_q <= cyc_q + 1'b1;
  end

  // R1: result appears exactly W cycles after the multiply is accepted
  assert_mul_len_R1: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (cyc_q == (CNT_W+1)'(W)));

  // R7: a start during a multiply does not restart the bit walk
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start && bit_q != '0) |=> (bit_q == $past(bit_q) - 1'b1));
endmodule

// File: rtl/ahl_bucket_decode.sv
module ahl_bucket_decode #(
  parameter int WORD_W = 64,
  parameter int PTR_W  = 20,
  parameter int TAG_W  = 32
) (
  input  logic [WORD_W-1:0] word,
  output logic              vld,
  output logic [2:0]        cnt,
  output logic [PTR_W-1:0]  ptr,
  output logic [TAG_W-1:0]  tag0
);
  localparam int HALF = WORD_W / 2;

  assign vld  = word[31];
  assign cnt  = word[30:28];
  assign ptr  = word[PTR_W-1:0];
  assign tag0 = word[HALF +: TAG_W];

  logic unused_bits;
  assign unused_bits = ^word[27:PTR_W];
endmodule

// File: rtl/ahl_tag_pair_cmp.sv
module ahl_tag_pair_cmp #(
  parameter int WORD_W = 64,
  parameter int TAG_W  = 32
) (
  input  logic [WORD_W-1:0] word,
  input  logic [TAG_W-1:0]  key,
  input  logic [2:0]        base_pos,
  input  logic [2:0]        count,
  output logic [1:0]        match
);
  localparam int HALF = WORD_W / 2;

  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic [3:0] pos;
    assign pos      = {1'b0, base_pos} + 4'(k);
    assign match[k] = (pos < {1'b0, count}) && (word[k*HALF +: TAG_W] == key);
  end
endmodule

// File: rtl/addr_hash_lookup.sv
module addr_hash_lookup
  import ahl_pkg::*;
#(
  parameter int IDX_W    = 16,
  parameter int PTR_W    = 20,
  parameter int WORD_W   = 64,
  parameter int MEM_AW   = 21,
  parameter int REC_BASE = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [47:0]       lookup_addr,
  input  logic [47:0]       hash_mult,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic              hit,
  output logic [PTR_W-1:0]  rec_idx
);
  localparam int TAG_W = HASH_W - IDX_W;
  localparam logic [MEM_AW-1:0] REC_BASE_A = MEM_AW'(REC_BASE);

  lk_state_e         state_q;
  logic              rd_en_q, done_q, hit_q;
  logic [MEM_AW-1:0] addr_q;
  logic [PTR_W-1:0]  idx_q, ptr_q;
  logic [TAG_W-1:0]  key_q;
  logic [2:0]        cnt_q;
  logic [1:0]        pair_q;

  logic              mul_start, mul_busy, mul_done;
  logic [HASH_W-1:0] prod;

  assign mul_start = start && (state_q == ST_IDLE);

  gf2_serial_mulmod #(.W(HASH_W), .POLY_LOW(GEN_LOW)) u_mul (
    .clk    (clk),
    .rst    (rst),
    .start  (mul_start),
    .a      (lookup_addr),
    .m      (hash_mult),
    .busy   (mul_busy),
    .done   (mul_done),
    .product(prod)
  );

  logic             bkt_vld;
  logic [2:0]       bkt_cnt;
  logic [PTR_W-1:0] bkt_ptr;
  logic [TAG_W-1:0] bkt_tag0;

  ahl_bucket_decode #(.WORD_W(WORD_W), .PTR_W(PTR_W), .TAG_W(TAG_W)) u_dec (
    .word(mem_rdata),
    .vld (bkt_vld),
    .cnt (bkt_cnt),
    .ptr (bkt_ptr),
    .tag0(bkt_tag0)
  );

  logic [2:0] base_pos;
  logic [1:0] lane_match;
  assign base_pos = {pair_q, 1'b1};

  ahl_tag_pair_cmp #(.WORD_W(WORD_W), .TAG_W(TAG_W)) u_cmp (
    .word    (mem_rdata),
    .key     (key_q),
    .base_pos(base_pos),
    .count   (cnt_q),
    .match   (lane_match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rd_en_q <= 1'b0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
      idx_q   <= '0;
      key_q   <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      pair_q  <= '0;
    end else begin
      done_q  <= 1'b0;
      rd_en_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) state_q <= ST_HASH;
        ST_HASH: if (mul_done) begin
          key_q   <= prod[HASH_W-1:IDX_W];
          addr_q  <= MEM_AW'(prod[IDX_W-1:0]);
          rd_en_q <= 1'b1;
          state_q <= ST_BKT_REQ;
        end
        ST_BKT_REQ: state_q <= ST_BKT_DATA;
        ST_BKT_DATA: begin
          if (!bkt_vld || bkt_cnt == 3'd0) begin
            done_q <= 1'b1; hit_q <= 1'b0; idx_q <= '0; state_q <= ST_IDLE;
          end else if (bkt_tag0 == key_q) begin
            done_q <= 1'b1; hit_q <= 1'b1; idx_q <= bkt_ptr; state_q <= ST_IDLE;
          end else if (bkt_cnt == 3'd1) begin
            done_q <= 1'b1; hit_q <= 1'b0; idx_q <= '0; state_q <= ST_IDLE;
          end else begin
            ptr_q   <= bkt_ptr;
            cnt_q   <= bkt_cnt;
            pair_q  <= 2'd0;
            addr_q  <= REC_BASE_A + MEM_AW'(bkt_ptr);
            rd_en_q <= 1'b1;
            state_q <= ST_REC_REQ;
          end
        end
        ST_REC_REQ: state_q <= ST_REC_DATA;
        ST_REC_DATA: begin
          if (lane_match[0]) begin
            done_q <= 1'b1; hit_q <= 1'b1; state_q <= ST_IDLE;
            idx_q  <= ptr_q + PTR_W'(base_pos);
          end else if (lane_match[1]) begin
            done_q <= 1'b1; hit_q <= 1'b1; state_q <= ST_IDLE;
            idx_q  <= ptr_q + PTR_W'(base_pos) + 1'b1;
          end else if ({1'b0, base_pos} + 4'd2 >= {1'b0, cnt_q}) begin
            done_q <= 1'b1; hit_q <= 1'b0; idx_q <= '0; state_q <= ST_IDLE;
          end else begin
            pair_q  <= pair_q + 1'b1;
            addr_q  <= REC_BASE_A + MEM_AW'(ptr_q) + MEM_AW'(pair_q) + 1'b1;
            rd_en_q <= 1'b1;
            state_q <= ST_REC_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_en = rd_en_q;
  assign mem_addr  = addr_q;
  assign done      = done_q;
  assign hit       = hit_q;
  assign rec_idx   = idx_q;

  // read counter per lookup, kept only for the bound check
  logic [2:0] rd_cnt_q;
  always_ff @(posedge clk) begin
    if (rst)            rd_cnt_q <= '0;
    else if (mul_start) rd_cnt_q <= '0;
    else if (rd_en_q)   rd_cnt_q <= rd_cnt_q + 1'b1;
  end

  assert_read_bound_R5: assert property (@(posedge clk) disable iff (rst)
    rd_cnt_q <= 3'd4);

  assert_read_spacing_R5: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !mul_busy);
endmodule

// File: tb/test_addr_hash_lookup.sv
`timescale 1ns/1ps
module test_addr_hash_lookup;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [47:0] lookup_addr = '0;
  logic [47:0] hash_mult = '0;
  logic        mem_rd_en;
  logic [20:0] mem_addr;
  logic [63:0] mem_rdata = '0;
  logic        done, hit;
  logic [19:0] rec_idx;

  localparam int REC_BASE = 65536;

  always #2.5 clk = ~clk;

  addr_hash_lookup i_addr_hash_lookup (
    .clk(clk), .rst(rst), .start(start), .lookup_addr(lookup_addr),
    .hash_mult(hash_mult), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .done(done), .hit(hit), .rec_idx(rec_idx)
  );

  logic [63:0] mem_m [int unsigned];

  function automatic logic [63:0] mem_rd(input logic [20:0] a);
    if (mem_m.exists(32'(a))) return mem_m[32'(a)];
    return 64'h0;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem_rd(mem_addr);

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // full product then long division by the generator
  function automatic logic [47:0] ref_hash(input logic [47:0] a, input logic [47:0] m);
    logic [94:0] p = '0;
    for (int i = 0; i < 48; i++) if (m[i]) p = p ^ ({47'b0, a} << i);
    for (int i = 94; i >= 48; i--)
      if (p[i]) p = p ^ ({46'b0, 49'h1_0010_0200_0401} << (i - 48));
    return p[47:0];
  endfunction

  typedef struct packed {
    logic [47:0] a;
    logic [47:0] m;
    logic [2:0]  cnt;
    logic [2:0]  tpos;   // 7 = key stored nowhere
    logic [19:0] ptr;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{48'h0123_4567_89AB, 48'h0000_0000_0001, 3'd1, 3'd0, 20'h00010},
    '{48'h8000_0000_0000, 48'h0000_0000_0002, 3'd1, 3'd7, 20'h00005},
    '{48'h0A0B_0C0D_0E0F, 48'h5DEE_CE66_D123, 3'd0, 3'd0, 20'h00020},
    '{48'hFFFF_0000_1234, 48'h8000_0000_0001, 3'd2, 3'd1, 20'h00100},
    '{48'h1357_9BDF_2468, 48'hA5A5_5A5A_C3C3, 3'd2, 3'd2, 20'h00200},
    '{48'hDEAD_BEEF_CAFE, 48'h1234_5678_9ABC, 3'd7, 3'd6, 20'h003F0},
    '{48'h0000_0000_0001, 48'hFFFF_FFFF_FFFF, 3'd7, 3'd7, 20'h00400},
    '{48'h7777_1111_3333, 48'h0F0F_F0F0_1357, 3'd5, 3'd4, 20'h00500},
    '{48'h2468_ACE0_1357, 48'h0000_8000_0000, 3'd4, 3'd3, 20'h00600},
    '{48'hCAFE_F00D_0042, 48'h3141_5926_5358, 3'd3, 3'd0, 20'h00077},
    '{48'h5555_AAAA_5555, 48'h2718_2818_2845, 3'd6, 3'd5, 20'h00800}
  };

  int          obs_reads;
  logic [20:0] obs_addr [8];
  logic        obs_done, obs_hit;
  logic [19:0] obs_idx;

  task automatic setup(input logic [47:0] a, input logic [47:0] m, input logic [2:0] cnt,
                       input logic [2:0] tpos, input logic [19:0] ptr, input bit dup);
    logic [47:0] h = ref_hash(a, m);
    logic [31:0] key = h[47:16];
    logic [31:0] tg [7];
    for (int p = 0; p < 7; p++)
      tg[p] = ((3'(p) == tpos) || (dup && 3'(p) == tpos + 3'd1)) ? key : key ^ (32'h1 << p);
    mem_m.delete();
    mem_m[32'(h[15:0])] = {tg[0], (cnt != 3'd0), cnt, 8'h00, ptr};
    for (int j = 0; j < 3; j++)
      mem_m[32'(REC_BASE) + 32'(ptr) + 32'(j)] = {tg[2*j+2], tg[2*j+1]};
  endtask

  task automatic run_lookup(input logic [47:0] a, input logic [47:0] m, input int inject);
    @(negedge clk);
    start = 1'b1; lookup_addr = a; hash_mult = m;
    @(negedge clk);
    start = 1'b0;
    obs_reads = 0; obs_done = 1'b0; obs_hit = 1'b0; obs_idx = '0;
    for (int c = 0; c < 400; c++) begin
      if (c == inject) begin start = 1'b1; lookup_addr = ~a; hash_mult = m ^ 48'h1; end
      else start = 1'b0;
      if (mem_rd_en) begin
        if (obs_reads < 8) obs_addr[obs_reads] = mem_addr;
        obs_reads++;
      end
      if (done) begin obs_done = 1'b1; obs_hit = hit; obs_idx = rec_idx; break; end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R6 done seen", 64'(obs_done), 64'h1);
    @(negedge clk);
    chk("R6 done one cycle", 64'(done), 64'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 done", 64'(done), 64'h0);
    chk("R8 hit", 64'(hit), 64'h0);
    chk("R8 rec_idx", 64'(rec_idx), 64'h0);
    chk("R8 mem_rd_en", 64'(mem_rd_en), 64'h0);

    foreach (VECS[v]) begin
      vec_t x = VECS[v];
      logic [47:0] h = ref_hash(x.a, x.m);
      bit   e_hit = (x.cnt != 3'd0) && (x.tpos < x.cnt);
      int   e_reads;
      if (x.cnt == 3'd0)  e_reads = 1;
      else if (e_hit)     e_reads = (x.tpos == 3'd0) ? 1 : 1 + (int'(x.tpos) + 1) / 2;
      else                e_reads = 1 + int'(x.cnt) / 2;
      setup(x.a, x.m, x.cnt, x.tpos, x.ptr, 1'b0);
      run_lookup(x.a, x.m, -1);
      chk("R1 bucket address", 64'(obs_addr[0]), 64'(h[15:0]));
      chk(x.cnt == 3'd0 ? "R2 empty miss" : (x.cnt == 3'd1 ? "R3 single" : "R4 search"),
          64'(obs_hit), 64'(e_hit));
      chk("R6 rec_idx", 64'(obs_idx), e_hit ? 64'(x.ptr + 20'(x.tpos)) : 64'h0);
      chk("R5 read count", 64'(obs_reads), 64'(e_reads));
      for (int k = 1; k < e_reads && k < 8; k++)
        chk("R4 record address", 64'(obs_addr[k]), 64'(REC_BASE + int'(x.ptr) + k - 1));
    end

    // R1: X * X^47 reduces to X^36+X^25+X^10+1 -> index 0x0401, tag 0x00100200
    mem_m.delete();
    mem_m[32'h401] = {32'h0010_0200, 1'b1, 3'd1, 8'h00, 20'h00009};
    run_lookup(48'h8000_0000_0000, 48'h2, -1);
    chk("R1 reduction index", 64'(obs_addr[0]), 64'h401);
    chk("R1 reduction tag hit", 64'(obs_hit), 64'h1);
    chk("R3 pointer index", 64'(obs_idx), 64'h9);

    // R4: key at positions 1 and 2 of one word, lower position wins
    setup(48'h0BAD_C0DE_0001, 48'h1111_2222_3333, 3'd3, 3'd1, 20'h00900, 1'b1);
    run_lookup(48'h0BAD_C0DE_0001, 48'h1111_2222_3333, -1);
    chk("R4 first match order", 64'(obs_idx), 64'h00901);
    chk("R4 first match reads", 64'(obs_reads), 64'h2);

    // R7: second start mid-hash ignored
    setup(VECS[0].a, VECS[0].m, VECS[0].cnt, VECS[0].tpos, VECS[0].ptr, 1'b0);
    run_lookup(VECS[0].a, VECS[0].m, 5);
    chk("R7 first result kept", 64'(obs_idx), 64'h00010);
    begin
      int extra = 0;
      for (int c = 0; c < 80; c++) begin
        if (done || mem_rd_en) extra++;
        @(negedge clk);
      end
      chk("R7 no second lookup", 64'(extra), 64'h0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule